// File: doc/BRIEF.md
# Open-Row Line-Fill Controller

This block refills instruction-cache lines from a backing array that behaves like a DRAM with one row buffer. The cache presents a line address with a valid/ready handshake. The controller splits the address into a row index (high bits) and a column (low bits), and compares the row with the single row it keeps open. It then steps through precharge, activate and column-access phases. Each phase lasts a parameterised number of memory clocks, and one memory clock is `CLK_RATIO` processor clocks.

On a row hit the precharge and activate phases are skipped, so only the column delay comes before the first beat. On a row miss all three phases run. The line is returned as a burst of bus-width beats in rising column order. Only the first beat can carry the row penalty, so a fill has one fixed latency for a hit and one for a miss. A row-hit flag comes with the first beat. A latency register holds the cycle count of the most recent fill so that it can be compared against the two expected values.

With the defaults (32-bit bus, 16-byte line, 4 beats, tCAS=2, tRCD=3, tRP=2, ratio 4), a fill takes 40 processor clocks on a hit and 60 on a miss. The first fill after reset takes 52, because no row is open and nothing needs to be precharged.

Top module: `rowbuf_fill_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `beat_valid` is 0, `row_hit` is 0 and `last_fill_cycles` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the cycle after acceptance, `req_ready` is 0 until the cycle after the last beat, when it returns to 1. A `req_valid` raised while `req_ready` is 0 starts no fill and does not change the fill in progress.
- R3: A fill delivers BEATS = LINE_BYTES*8/BUS_W beats (4 by default). Each beat is a one-cycle `beat_valid` pulse. Beat k carries the array word at word index (line word index + k). The array word at index w has every even 16-bit lane (lane 0 = bits 15:0) equal to w zero-extended to 16 bits, and every odd lane equal to the bitwise inverse of that value. `beat_first` marks beat 0 and `beat_last` marks beat BEATS-1.
- R4: Count the accepting edge as edge 0. On a row hit, beat k is valid in the cycle that ends at edge CLK_RATIO*(T_CAS + 2*(k+1)), so the last beat ends at edge 40 by default.
- R5: On a row miss while another row is open, every beat comes CLK_RATIO*(T_RP + T_RCD) cycles later than on a hit. The last beat ends at edge 60 by default.
- R6: With RESET_PRECHARGE=0, the first fill after reset is a row miss that skips precharge. Every beat comes CLK_RATIO*T_RCD cycles later than on a hit, so the last beat ends at edge 52 by default.
- R7: A request is a row hit exactly when a row is open and the request's row bits (address bits ADDR_W-1 down to log2(ROW_BYTES), i.e. bits 11:8 by default) equal those of the most recent fill.
- R8: `row_hit` is 1 only in the cycle of the first beat, and only for a row hit. For a miss it stays 0 throughout the fill.
- R9: Address bits below log2(LINE_BYTES) are ignored. An unaligned request returns the same beats as the aligned address of its line.
- R10: From the cycle after a fill's last beat until the last beat of the next fill, `last_fill_cycles` holds the number of edges from the accepting edge to the end of the last beat (40, 52 or 60 by default).
- R11: A miss makes its row the open row. After a miss to row B, a request to the row that was open before it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | ADDR_W | Byte address of the line to fill |
| beat_valid | output | 1 | One beat of line data is present |
| beat_data | output | BUS_W | Beat payload |
| beat_first | output | 1 | Marks the first beat of a fill |
| beat_last | output | 1 | Marks the final beat of a fill |
| row_hit | output | 1 | With the first beat: the fill found its row already open |
| last_fill_cycles | output | LAT_W | Accept-to-last-beat cycle count of the most recent fill |

## Verification
The hardest case to reach from the ports is a request that arrives while a fill is in flight. It must be ignored without moving the beat timing or corrupting the open row. The bench raises `req_valid` with an address in a different row partway through a miss fill, and drops it before the fill ends. It then checks that the burst keeps its expected cycles and data and that no second burst follows. The cold-start path can only be seen once per reset, so the bench's first fill targets it. Open-row replacement is shown by returning to a former row after a miss and observing the full miss latency.

// File: rtl/rowbuf_pkg.sv
`timescale 1ns/1ps
package rowbuf_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_ACT,
      PH_CAS,
      PH_XFER
   } phase_t;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rowbuf_tracker.sv
`timescale 1ns/1ps
module rowbuf_tracker #(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] lookup_row,
   input  logic             capture,
   input  logic [ROW_W-1:0] capture_row,
   output logic             lookup_hit,
   output logic             row_open
);

   logic             open_q;
   logic [ROW_W-1:0] open_row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         open_row_q <= '0;
      end else if (capture) begin
         open_q     <= 1'b1;
         open_row_q <= capture_row;
      end
   end

   assign lookup_hit = open_q && (open_row_q == lookup_row);
   assign row_open   = open_q;

endmodule

// File: rtl/rowbuf_seq.sv
`timescale 1ns/1ps
module rowbuf_seq
   import rowbuf_pkg::*;
#(
   parameter int T_CAS           = 2,
   parameter int T_RCD           = 3,
   parameter int T_RP            = 2,
   parameter int BEAT_MCLK       = 2,
   parameter int CLK_RATIO       = 4,
   parameter int BEATS           = 4,
   parameter bit RESET_PRECHARGE = 1'b0,
   localparam int BEAT_W         = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hit_in,
   input  logic              row_open,
   output logic              busy,
   output logic              act_enter,
   output logic              strobe,
   output logic              strobe_last,
   output logic [BEAT_W-1:0] beat_idx
);

   localparam int MAX_MCLK = max_of4(T_CAS, T_RCD, T_RP, BEAT_MCLK);
   localparam int CNT_W    = $clog2(MAX_MCLK * CLK_RATIO + 1);
   localparam logic [CNT_W-1:0] RP_LOAD   = CNT_W'(T_RP * CLK_RATIO - 1);
   localparam logic [CNT_W-1:0] ACT_LOAD  = CNT_W'(T_RCD * CLK_RATIO - 1);
   localparam logic [CNT_W-1:0] CAS_LOAD  = CNT_W'(T_CAS * CLK_RATIO - 1);
   localparam logic [CNT_W-1:0] XFER_LOAD = CNT_W'(BEAT_MCLK * CLK_RATIO - 1);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   phase_t            ph_q;
   phase_t            cold_ph;
   phase_t            entry_ph;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  entry_load;
   logic [BEAT_W-1:0] beat_q;
   logic              cnt_zero;

   if (RESET_PRECHARGE) begin : g_cold_precharge
      assign cold_ph = PH_PRE;
   end else begin : g_cold_activate
      assign cold_ph = PH_ACT;
   end

   always_comb begin
      if (hit_in)         entry_ph = PH_CAS;
      else if (!row_open) entry_ph = cold_ph;
      else                entry_ph = PH_PRE;
   end

   always_comb begin
      case (entry_ph)
         PH_PRE:  entry_load = RP_LOAD;
         PH_ACT:  entry_load = ACT_LOAD;
         default: entry_load = CAS_LOAD;
      endcase
   end

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         beat_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q   <= entry_ph;
                  cnt_q  <= entry_load;
                  beat_q <= '0;
               end
            end
            PH_PRE: begin
               if (cnt_zero) begin
                  ph_q  <= PH_ACT;
                  cnt_q <= ACT_LOAD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_ACT: begin
               if (cnt_zero) begin
                  ph_q  <= PH_CAS;
                  cnt_q <= CAS_LOAD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_CAS: begin
               if (cnt_zero) begin
                  ph_q  <= PH_XFER;
                  cnt_q <= XFER_LOAD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_XFER: begin
               if (cnt_zero) begin
                  if (beat_q == LAST_BEAT) begin
                     ph_q <= PH_IDLE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                     cnt_q  <= XFER_LOAD;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy        = (ph_q != PH_IDLE);
   assign act_enter   = ((ph_q == PH_PRE) && cnt_zero) ||
                        ((ph_q == PH_IDLE) && start && (entry_ph == PH_ACT));
   assign strobe      = (ph_q == PH_XFER) && cnt_zero;
   assign strobe_last = strobe && (beat_q == LAST_BEAT);
   assign beat_idx    = beat_q;

endmodule

// File: rtl/rowbuf_array.sv
`timescale 1ns/1ps
module rowbuf_array #(
   parameter int WORD_W = 10,
   parameter int BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rd_word,
   output logic [BUS_W-1:0]  rd_data
);

   localparam int LANES = BUS_W / 16;

   logic [BUS_W-1:0] pattern;
   logic [15:0]      base;

   assign base = 16'(rd_word);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if ((l % 2) == 0) begin : g_even
         assign pattern[l*16 +: 16] = base;
      end else begin : g_odd
         assign pattern[l*16 +: 16] = ~base;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= pattern;
   end

endmodule

// File: rtl/rowbuf_fill_ctrl.sv
`timescale 1ns/1ps
module rowbuf_fill_ctrl #(
   parameter int ADDR_W          = 12,
   parameter int BUS_W           = 32,
   parameter int LINE_BYTES      = 16,
   parameter int ROW_BYTES       = 256,
   parameter int T_CAS           = 2,
   parameter int T_RCD           = 3,
   parameter int T_RP            = 2,
   parameter int BEAT_MCLK       = 2,
   parameter int CLK_RATIO       = 4,
   parameter int LAT_W           = 16,
   parameter bit RESET_PRECHARGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              beat_valid,
   output logic [BUS_W-1:0]  beat_data,
   output logic              beat_first,
   output logic              beat_last,
   output logic              row_hit,
   output logic [LAT_W-1:0]  last_fill_cycles
);

   localparam int BUS_BYTES  = BUS_W / 8;
   localparam int BEATS      = LINE_BYTES / BUS_BYTES;
   localparam int LINE_OFS_W = $clog2(LINE_BYTES);
   localparam int WORD_SH    = $clog2(BUS_BYTES);
   localparam int BEAT_W     = LINE_OFS_W - WORD_SH;
   localparam int COL_W      = $clog2(ROW_BYTES);
   localparam int ROW_W      = ADDR_W - COL_W;
   localparam int LINE_W     = ADDR_W - LINE_OFS_W;
   localparam int WORD_W     = ADDR_W - WORD_SH;

   if ((BUS_W % 16) != 0 || BUS_W < 16) begin : g_bad_bus
      $error("BUS_W must be a positive multiple of 16");
   end
   if ((1 << LINE_OFS_W) != LINE_BYTES || BEATS < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two beats");
   end
   if ((1 << COL_W) != ROW_BYTES || ROW_BYTES < LINE_BYTES || COL_W >= ADDR_W) begin : g_bad_row
      $error("ROW_BYTES must be a power of two between the line size and the address space");
   end
   if (T_CAS < 1 || T_RCD < 1 || T_RP < 1 || BEAT_MCLK < 1 || CLK_RATIO < 1 ||
       BEAT_MCLK * CLK_RATIO < 2) begin : g_bad_timing
      $error("timing parameters must be positive and a beat must span two cycles");
   end
   if (LAT_W < $clog2(CLK_RATIO * (T_RP + T_RCD + T_CAS + BEATS * BEAT_MCLK) + 1)) begin : g_bad_lat
      $error("LAT_W too narrow for the miss latency");
   end

   logic              busy;
   logic              accept;
   logic              act_enter;
   logic              strobe;
   logic              strobe_last;
   logic [BEAT_W-1:0] beat_idx;
   logic              lookup_hit;
   logic              row_open;
   logic [ROW_W-1:0]  req_row;
   logic [ROW_W-1:0]  row_q;
   logic [ROW_W-1:0]  cap_row;
   logic [LINE_W-1:0] line_q;
   logic              hit_q;
   logic [LAT_W-1:0]  elapsed_q;
   logic [LAT_W-1:0]  lat_q;
   logic [WORD_W-1:0] rd_word;
   logic [BUS_W-1:0]  rd_data;
   logic              unused_line_ofs;

   assign unused_line_ofs = ^req_addr[LINE_OFS_W-1:0];

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign req_row   = req_addr[ADDR_W-1:COL_W];
   assign cap_row   = busy ? row_q : req_row;

   rowbuf_tracker #(.ROW_W(ROW_W)) u_tracker (
      .clk        (clk),
      .rst_n      (rst_n),
      .lookup_row (req_row),
      .capture    (act_enter),
      .capture_row(cap_row),
      .lookup_hit (lookup_hit),
      .row_open   (row_open)
   );

   rowbuf_seq #(
      .T_CAS          (T_CAS),
      .T_RCD          (T_RCD),
      .T_RP           (T_RP),
      .BEAT_MCLK      (BEAT_MCLK),
      .CLK_RATIO      (CLK_RATIO),
      .BEATS          (BEATS),
      .RESET_PRECHARGE(RESET_PRECHARGE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .hit_in     (lookup_hit),
      .row_open   (row_open),
      .busy       (busy),
      .act_enter  (act_enter),
      .strobe     (strobe),
      .strobe_last(strobe_last),
      .beat_idx   (beat_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q  <= '0;
         line_q <= '0;
         hit_q  <= 1'b0;
      end else if (accept) begin
         row_q  <= req_row;
         line_q <= req_addr[ADDR_W-1:LINE_OFS_W];
         hit_q  <= lookup_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed_q <= '0;
         lat_q     <= '0;
      end else begin
         if (accept)    elapsed_q <= '0;
         else if (busy) elapsed_q <= elapsed_q + 1'b1;
         if (strobe_last) lat_q <= elapsed_q + 1'b1;
      end
   end

   assign rd_word = {line_q, beat_idx};

   rowbuf_array #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_word(rd_word),
      .rd_data(rd_data)
   );

   assign beat_valid       = strobe;
   assign beat_data        = strobe ? rd_data : '0;
   assign beat_first       = strobe && (beat_idx == '0);
   assign beat_last        = strobe_last;
   assign row_hit          = beat_first && hit_q;
   assign last_fill_cycles = lat_q;

endmodule

// File: rtl/rowbuf_fill_chk.sv
`timescale 1ns/1ps
module rowbuf_fill_chk #(
   parameter int ADDR_W = 12,
   parameter int BUS_W  = 32,
   parameter int LAT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              beat_valid,
   input logic [BUS_W-1:0]  beat_data,
   input logic              beat_first,
   input logic              beat_last,
   input logic              row_hit,
   input logic [LAT_W-1:0]  last_fill_cycles
);

   logic unused_chk;
   assign unused_chk = ^{req_addr, beat_data};

   // R2
   accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2
   busy_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !req_ready);

   // R2
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_last) |=> req_ready);

   // R2
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !(beat_valid && beat_last)) |=> !req_ready);

   // R3
   beat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |=> !beat_valid);

   // R3
   beat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_first || beat_last) |-> beat_valid);

   // R8
   hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit |-> (beat_valid && beat_first));

   // R10
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(beat_valid && beat_last) |=> $stable(last_fill_cycles));

endmodule

bind rowbuf_fill_ctrl rowbuf_fill_chk #(
   .ADDR_W(ADDR_W),
   .BUS_W (BUS_W),
   .LAT_W (LAT_W)
) u_fill_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_ready       (req_ready),
   .req_addr        (req_addr),
   .beat_valid      (beat_valid),
   .beat_data       (beat_data),
   .beat_first      (beat_first),
   .beat_last       (beat_last),
   .row_hit         (row_hit),
   .last_fill_cycles(last_fill_cycles)
);

// File: tb/rowbuf_fill_ctrl_test.sv
`timescale 1ns/1ps
module rowbuf_fill_ctrl_test;

   localparam int R     = 4;
   localparam int TCAS  = 2;
   localparam int BMCLK = 2;
   localparam int NBEAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_addr = '0;
   logic        beat_valid;
   logic [31:0] beat_data;
   logic        beat_first;
   logic        beat_last;
   logic        row_hit;
   logic [15:0] last_fill_cycles;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   rowbuf_fill_ctrl uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .req_ready       (req_ready),
      .req_addr        (req_addr),
      .beat_valid      (beat_valid),
      .beat_data       (beat_data),
      .beat_first      (beat_first),
      .beat_last       (beat_last),
      .row_hit         (row_hit),
      .last_fill_cycles(last_fill_cycles)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [11:0] a, input int k);
      logic [9:0]  w;
      logic [15:0] x;
      w = {a[11:4], 2'b00} + 10'(k);
      x = {6'b0, w};
      return {~x, x};
   endfunction

   // Runs one fill; pen is the extra memory clocks before the first beat.
   task automatic do_fill(input string req, input logic [11:0] addr,
                          input bit exp_hit, input int pen, input bit intrude);
      int  total;
      int  bad_timing;
      bit  seen_ready;
      total = R * (pen + TCAS + NBEAT * BMCLK);
      bad_timing = 0;
      @(negedge clk);
      check(req_ready == 1'b1, req, "ready before request", 64'(req_ready), 64'd1);
      req_addr  = addr;
      req_valid = 1'b1;
      @(posedge clk);
      for (int c = 0; c <= total; c++) begin
         @(negedge clk);
         if (c == 0) req_valid = 1'b0;
         if (intrude && c == 6) begin
            req_valid = 1'b1;
            req_addr  = 12'h7A0;
         end
         if (intrude && c == total - 2) req_valid = 1'b0;
         if (c == total) begin
            check(req_ready == 1'b1, "R2", "ready after last beat", 64'(req_ready), 64'd1);
            check(last_fill_cycles == 16'(total), "R10", "fill latency",
                  64'(last_fill_cycles), 64'(total));
         end else begin
            bit exp_v;
            int k;
            exp_v = 1'b0;
            k = 0;
            for (int b = 0; b < NBEAT; b++)
               if (c == R * (pen + TCAS + BMCLK * (b + 1)) - 1) begin
                  exp_v = 1'b1;
                  k = b;
               end
            if (req_ready !== 1'b0 || beat_valid !== exp_v) bad_timing++;
            if (exp_v) begin
               check(beat_data == exp_word(addr, k), "R3", $sformatf("%s beat %0d data", req, k),
                     64'(beat_data), 64'(exp_word(addr, k)));
               check(beat_first == (k == 0) && beat_last == (k == NBEAT - 1), "R3",
                     "first/last flags", 64'({beat_first, beat_last}),
                     64'({k == 0, k == NBEAT - 1}));
               check(row_hit == (exp_hit && k == 0), "R8", $sformatf("%s row_hit beat %0d", req, k),
                     64'(row_hit), 64'(exp_hit && k == 0));
            end
         end
      end
      check(bad_timing == 0, req, "beat timing and ready low during fill",
            64'(bad_timing), 64'd0);
      if (intrude) begin
         seen_ready = 1'b1;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (beat_valid !== 1'b0 || req_ready !== 1'b1) seen_ready = 1'b0;
         end
         check(seen_ready, "R2", "request during busy ignored", 64'(seen_ready), 64'd1);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_ready == 1'b1 && beat_valid == 1'b0 && row_hit == 1'b0, "R1",
            "reset outputs", 64'({req_ready, beat_valid, row_hit}), 64'b100);
      check(last_fill_cycles == 16'd0, "R1", "reset latency", 64'(last_fill_cycles), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && beat_valid == 1'b0, "R1", "after reset",
            64'({req_ready, beat_valid}), 64'b10);
   endtask

   task automatic t_cold();
      do_fill("R6", 12'h120, 1'b0, 3, 1'b0);      // cold miss, no precharge: 52
   endtask

   task automatic t_hit();
      do_fill("R4", 12'h130, 1'b1, 0, 1'b0);      // R7 same row bits 11:8
   endtask

   task automatic t_unaligned();
      do_fill("R9", 12'h12D, 1'b1, 0, 1'b0);
   endtask

   task automatic t_miss_intrude();
      do_fill("R5", 12'h340, 1'b0, 5, 1'b1);
   endtask

   task automatic t_return_row();
      do_fill("R11", 12'h1F0, 1'b0, 5, 1'b0);     // row 1 was replaced by row 3
      do_fill("R7", 12'h1F0, 1'b1, 0, 1'b0);
   endtask

   task automatic t_top_line();
      do_fill("R5", 12'hFF0, 1'b0, 5, 1'b0);
      do_fill("R7", 12'hF00, 1'b1, 0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_cold();
      t_hit();
      t_unaligned();
      t_miss_intrude();
      t_return_row();
      t_top_line();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule